// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This block sits between a 32-bit core and a byte-addressed, little-endian data memory that is one or more 32-bit words wide. For a store, it takes the byte offset of the access inside the memory word, a 2-bit write-size code and the 32-bit store value. It returns one byte-enable bit per memory lane and a write word in which the store value is copied onto every lane position it could occupy. The memory only needs to honour the enables.

For a load, it takes a 2-bit read-size code, a sign flag and the raw memory read word. It selects the addressed byte, halfword or word and widens it to a 32-bit register value, using either sign extension or zero extension. The whole unit is combinational. Alignment faults, bus handshaking and the memory itself belong to other blocks.

Top module: `lsu_lane_unit`

## Requirements
- R1: Write-size code 2'b01 (byte) sets exactly one byte-enable bit, bit number equal to the byte offset.
- R2: Write-size code 2'b10 (halfword) enables the two lanes of the naturally aligned halfword holding the offset: for a 32-bit memory, 4'b0011 when offset bit 1 is 0 and 4'b1100 when it is 1. Offset bit 0 is ignored.
- R3: Write-size code 2'b11 (word) enables the four lanes of the aligned word holding the offset: 4'b1111 for a 32-bit memory. Offset bits 1:0 are ignored.
- R4: Write-size code 2'b00 (no write) drives the byte-enable and the write data to all zeros.
- R5: The write data holds store bits 7:0 on every lane for a byte store, store bits 15:0 in every halfword slot for a halfword store, and the full store value in every word slot for a word store. The sign flag has no effect on either store output.
- R6: Read-size code 2'b01 with sign flag 1 returns the byte on lane offset, sign-extended from its bit 7.
- R7: Read-size code 2'b01 with sign flag 0 returns the byte on lane offset with bits 31:8 zero.
- R8: Read-size code 2'b10 returns the aligned halfword selected by offset bit 1 (bits 15:0 or 31:16 of a 32-bit word). It is sign-extended from its bit 15 when the sign flag is 1 and zero-extended when the flag is 0. Offset bit 0 is ignored.
- R9: Read-size code 2'b11 returns the aligned 32-bit word unchanged, for any sign flag and any offset bits 1:0.
- R10: Read-size code 2'b00 (no read) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| off_i | input | OFF_W (2) | Byte offset of the access inside the memory word |
| wr_size_i | input | 2 | Write-size code: 00 none, 01 byte, 10 halfword, 11 word |
| st_data_i | input | 32 | Store value from the core, right-aligned |
| rd_size_i | input | 2 | Read-size code: 00 none, 01 byte, 10 halfword, 11 word |
| ld_signed_i | input | 1 | 1 = sign-extend a byte or halfword load, 0 = zero-extend |
| mem_rdata_i | input | MEM_W (32) | Raw word read from memory |
| mem_be_o | output | MEM_W/8 (4) | Per-lane byte enable toward memory |
| mem_wdata_o | output | MEM_W (32) | Lane-replicated write data toward memory |
| ld_data_o | output | 32 | Extended load result for the core |

## Verification
The bench builds the unit with its default 32-bit memory width, which has only four lanes and two offset bits. With that configuration every combination of size code, offset and sign flag can be enumerated in full. For each combination, several store values and read words are applied whose bytes have their top bit both set and clear, so both extension directions and each lane's own bytes show up distinctly on the outputs. The enables and write word are also checked for independence from the sign flag.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

   localparam int unsigned XLEN = 32;

   typedef enum logic [1:0] {
      SZ_NONE = 2'b00,
      SZ_BYTE = 2'b01,
      SZ_HALF = 2'b10,
      SZ_WORD = 2'b11
   } acc_size_e;

   // number of bytes an access of the given size touches
   function automatic int unsigned size_bytes(acc_size_e s);
      case (s)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         SZ_WORD: return 4;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/lsu_sign_extend.sv
module lsu_sign_extend #(
   parameter int unsigned IN_W  = 8,
   parameter int unsigned OUT_W = 32
) (
   input  logic [IN_W-1:0]  val_i,
   input  logic             signed_i,
   output logic [OUT_W-1:0] val_o
);
   localparam int unsigned PAD_W = OUT_W - IN_W;

   if (IN_W == 0 || IN_W >= OUT_W) begin : g_bad_width
      $error("lsu_sign_extend: IN_W must be in 1..OUT_W-1");
   end

   logic fill;
   assign fill  = signed_i & val_i[IN_W-1];
   assign val_o = {{PAD_W{fill}}, val_i};

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_lane_pkg::*;
#(
   parameter int unsigned MEM_W = 32,
   parameter int unsigned OFF_W = $clog2(MEM_W / 8)
) (
   input  logic [OFF_W-1:0]   off_i,
   input  acc_size_e          size_i,
   input  logic [XLEN-1:0]    data_i,
   output logic [MEM_W/8-1:0] be_o,
   output logic [MEM_W-1:0]   wdata_o
);
   localparam int unsigned LANES = MEM_W / 8;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [OFF_W-1:0] IDX = OFF_W'(g);
      localparam int unsigned HB = g % 2;
      localparam int unsigned WB = g % 4;

      always_comb begin
         be_o[g]          = 1'b0;
         wdata_o[8*g +: 8] = 8'h00;
         case (size_i)
            SZ_BYTE: begin
               be_o[g]           = (off_i == IDX);
               wdata_o[8*g +: 8] = data_i[7:0];
            end
            SZ_HALF: begin
               be_o[g]           = ((off_i >> 1) == (IDX >> 1));
               wdata_o[8*g +: 8] = data_i[8*HB +: 8];
            end
            SZ_WORD: begin
               be_o[g]           = ((off_i >> 2) == (IDX >> 2));
               wdata_o[8*g +: 8] = data_i[8*WB +: 8];
            end
            default: ;
         endcase
      end
   end

   always_comb begin : chk
      if (!$isunknown({size_i, off_i, be_o})) begin
         if (size_i == SZ_BYTE) AST_BYTE_ONE_LANE: assert ($onehot(be_o)) else $error("byte store lane count"); // R1
         if (size_i == SZ_HALF) AST_HALF_TWO_LANES: assert ($countones(be_o) == 2 && (be_o & (be_o >> 1)) != '0) else $error("half store lanes"); // R2
         if (size_i == SZ_WORD) AST_WORD_FOUR_LANES: assert ($countones(be_o) == size_bytes(SZ_WORD)) else $error("word store lanes"); // R3
         if (size_i == SZ_NONE) AST_IDLE_NO_ENABLE: assert (be_o == '0 && wdata_o == '0) else $error("idle store active"); // R4
      end
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_lane_pkg::*;
#(
   parameter int unsigned MEM_W = 32,
   parameter int unsigned OFF_W = $clog2(MEM_W / 8)
) (
   input  logic [OFF_W-1:0] off_i,
   input  acc_size_e        size_i,
   input  logic             signed_i,
   input  logic [MEM_W-1:0] rdata_i,
   output logic [XLEN-1:0]  ld_o
);
   localparam logic [OFF_W-1:0] HALF_MASK = ~OFF_W'(1);
   localparam logic [OFF_W-1:0] WORD_MASK = ~OFF_W'(3);

   logic [OFF_W-1:0] half_off, word_off;
   logic [7:0]       byte_sel;
   logic [15:0]      half_sel;
   logic [XLEN-1:0]  word_sel, byte_ext, half_ext;

   assign half_off = off_i & HALF_MASK;
   assign word_off = off_i & WORD_MASK;

   assign byte_sel = rdata_i[{off_i, 3'b000} +: 8];
   assign half_sel = rdata_i[{half_off, 3'b000} +: 16];
   assign word_sel = rdata_i[{word_off, 3'b000} +: XLEN];

   lsu_sign_extend #(.IN_W(8), .OUT_W(XLEN)) u_ext_byte (
      .val_i(byte_sel), .signed_i(signed_i), .val_o(byte_ext)
   );
   lsu_sign_extend #(.IN_W(16), .OUT_W(XLEN)) u_ext_half (
      .val_i(half_sel), .signed_i(signed_i), .val_o(half_ext)
   );

   always_comb begin
      case (size_i)
         SZ_BYTE: ld_o = byte_ext;
         SZ_HALF: ld_o = half_ext;
         SZ_WORD: ld_o = word_sel;
         default: ld_o = '0;
      endcase
   end

   always_comb begin : chk
      if (!$isunknown({size_i, signed_i, ld_o})) begin
         if (size_i == SZ_BYTE && signed_i) AST_BYTE_SIGN_FILL: assert (ld_o[31:8] == {24{ld_o[7]}}) else $error("byte sign fill"); // R6
         if (size_i == SZ_BYTE && !signed_i) AST_BYTE_ZERO_FILL: assert (ld_o[31:8] == '0) else $error("byte zero fill"); // R7
         if (size_i == SZ_HALF) AST_HALF_FILL: assert (ld_o[31:16] == (signed_i ? {16{ld_o[15]}} : 16'h0)) else $error("half fill"); // R8
         if (size_i == SZ_NONE) AST_NOREAD_ZERO: assert (ld_o == '0) else $error("idle load nonzero"); // R10
      end
   end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
   import lsu_lane_pkg::*;
#(
   parameter int unsigned MEM_W = 32,
   parameter int unsigned OFF_W = $clog2(MEM_W / 8)
) (
   input  logic [OFF_W-1:0]   off_i,
   input  logic [1:0]         wr_size_i,
   input  logic [XLEN-1:0]    st_data_i,
   input  logic [1:0]         rd_size_i,
   input  logic               ld_signed_i,
   input  logic [MEM_W-1:0]   mem_rdata_i,
   output logic [MEM_W/8-1:0] mem_be_o,
   output logic [MEM_W-1:0]   mem_wdata_o,
   output logic [XLEN-1:0]    ld_data_o
);
   if (MEM_W < XLEN || (MEM_W & (MEM_W - 1)) != 0) begin : g_bad_mem
      $error("lsu_lane_unit: MEM_W must be a power of two of at least 32");
   end
   if (OFF_W != $clog2(MEM_W / 8)) begin : g_bad_off
      $error("lsu_lane_unit: OFF_W must match the lane count");
   end

   acc_size_e wr_size, rd_size;
   assign wr_size = acc_size_e'(wr_size_i);
   assign rd_size = acc_size_e'(rd_size_i);

   lsu_store_lanes #(.MEM_W(MEM_W), .OFF_W(OFF_W)) u_store (
      .off_i  (off_i),
      .size_i (wr_size),
      .data_i (st_data_i),
      .be_o   (mem_be_o),
      .wdata_o(mem_wdata_o)
   );

   lsu_load_extract #(.MEM_W(MEM_W), .OFF_W(OFF_W)) u_load (
      .off_i   (off_i),
      .size_i  (rd_size),
      .signed_i(ld_signed_i),
      .rdata_i (mem_rdata_i),
      .ld_o    (ld_data_o)
   );

endmodule

// File: tb/lsu_lane_unit_bench.sv
module lsu_lane_unit_bench;
   logic        clk = 1'b0;
   logic [1:0]  off = '0;
   logic [1:0]  wr_size = '0;
   logic [31:0] st_data = '0;
   logic [1:0]  rd_size = '0;
   logic        ld_signed = 1'b0;
   logic [31:0] rdata = '0;
   logic [3:0]  be;
   logic [31:0] wdata, ld_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   lsu_lane_unit u_lsu_lane_unit (
      .off_i(off), .wr_size_i(wr_size), .st_data_i(st_data),
      .rd_size_i(rd_size), .ld_signed_i(ld_signed), .mem_rdata_i(rdata),
      .mem_be_o(be), .mem_wdata_o(wdata), .ld_data_o(ld_data)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_be(int w, int o);
      case (w)
         1: return 4'(1 << o);
         2: return 4'(3 << (o & 2));
         3: return 4'hF;
         default: return 4'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_wd(int w, logic [31:0] d);
      case (w)
         1: return {4{d[7:0]}};
         2: return {2{d[15:0]}};
         3: return d;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_ld(int r, int o, bit s, logic [31:0] w);
      logic [31:0] v;
      case (r)
         1: begin
            v = (w >> (8 * o)) & 32'hFF;
            if (s && v[7]) v = v | 32'hFFFF_FF00;
         end
         2: begin
            v = (w >> (16 * (o / 2))) & 32'hFFFF;
            if (s && v[15]) v = v | 32'hFFFF_0000;
         end
         3: v = w;
         default: v = 32'h0;
      endcase
      return v;
   endfunction

   localparam logic [31:0] PAT [4] = '{32'hF1E2_D3C4, 32'h7F01_7E02, 32'h80FF_0080, 32'h1234_5678};

   initial begin
      @(negedge clk);
      // idle state with no access requested
      check("R4 idle enable", {28'h0, be}, 32'h0);
      check("R4 idle wdata", wdata, 32'h0);
      check("R10 idle load", ld_data, 32'h0);

      // stores: every size, offset, sign flag and several values
      for (int w = 0; w < 4; w++)
         for (int o = 0; o < 4; o++)
            for (int s = 0; s < 2; s++)
               for (int p = 0; p < 4; p++) begin
                  wr_size = 2'(w); off = 2'(o); ld_signed = s[0]; st_data = PAT[p];
                  @(negedge clk);
                  case (w)
                     1: check("R1 byte enable", {28'h0, be}, {28'h0, exp_be(w, o)});
                     2: check("R2 half enable", {28'h0, be}, {28'h0, exp_be(w, o)});
                     3: check("R3 word enable", {28'h0, be}, {28'h0, exp_be(w, o)});
                     default: check("R4 no-write enable", {28'h0, be}, 32'h0);
                  endcase
                  if (w == 0) check("R4 no-write data", wdata, 32'h0);
                  else        check("R5 replicated data", wdata, exp_wd(w, PAT[p]));
               end
      wr_size = 2'b00;

      // loads: every size, offset, sign flag and several read words
      for (int r = 0; r < 4; r++)
         for (int o = 0; o < 4; o++)
            for (int s = 0; s < 2; s++)
               for (int p = 0; p < 4; p++) begin
                  rd_size = 2'(r); off = 2'(o); ld_signed = s[0]; rdata = PAT[p];
                  @(negedge clk);
                  case (r)
                     1: if (s == 1) check("R6 signed byte", ld_data, exp_ld(r, o, 1'b1, PAT[p]));
                        else        check("R7 unsigned byte", ld_data, exp_ld(r, o, 1'b0, PAT[p]));
                     2: check("R8 halfword", ld_data, exp_ld(r, o, s[0], PAT[p]));
                     3: check("R9 word", ld_data, exp_ld(r, o, s[0], PAT[p]));
                     default: check("R10 no-read", ld_data, 32'h0);
                  endcase
               end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule